// File: doc/BRIEF.md
# Slope-to-Phase Spectral Filter

This block is the frequency-domain combining stage of a modal Fourier wavefront reconstructor. It takes two lock-stepped streams of complex spectrum points on an N x N grid (8 x 8 by default). One stream is the 2-D transform of the x-gradient map and the other is the transform of the y-gradient map. Each point arrives with its row index p and column index q. For every point the block forms the phase-spectrum coefficient j·(p·FX + q·FY)/(p² + q²). It does this by weighting each stream with a complex constant and adding the two products. It then rounds the result to the word width that the inverse transform expects.

Both gradients read their weights from one constant table. The y weight of point (p,q) equals the x weight of point (q,p), so the y path reads the same table with its two indices swapped. Each path runs through a pipelined complex multiplier built from four real multipliers. One registered adder then combines the paths. A row or column index at or above N/2 stands for a negative spatial frequency. Points can arrive back to back or with gaps. Each result comes out a fixed number of cycles later, together with its own indices.

Top module: `sf_slope_filter`

## Requirements
- R1: For index i in 0..N-1 let s(i) = i when i < N/2, otherwise i - N. Let T(a,b) = s(a)·2^14/(s(a)²+s(b)²) rounded to the nearest integer, with halves going away from zero, and T = 0 when s(a) = s(b) = 0. Each input word first goes through the R5 rounding to give Xr, Xi, Yr, Yi. The full-precision sum is then re = -(Xi·T(p,q) + Yi·T(q,p)) and im = Xr·T(p,q) + Yr·T(q,p).
- R2: The y path uses the table entry at the swapped position (q,p), so a point with p ≠ q weights the two streams differently.
- R3: Row and column indices at or above N/2 are treated as negative frequencies, following s(i) in R1. For example, index 4 with N = 8 means frequency -4.
- R4: The point p = q = 0 always produces re = im = 0, whatever its inputs are.
- R5: Each 24-bit input word is reduced to 18 bits. The block adds 32, shifts right arithmetically by 6 and clamps the result to [-131072, 131071].
- R6: Each 16-bit output word is computed from its R1 sum. The block adds 2^15, shifts right arithmetically by 16 and clamps the result to [-32768, 32767].
- R7: out_vld rises exactly 7 clock edges after the edge that accepted the point with in_vld high. The block accepts a new point on every cycle.
- R8: out_row and out_col carry the p and q of the point whose coefficient is on out_re and out_im.
- R9: In cycles where out_vld is low, out_re and out_im keep their previous values.
- R10: While reset is active, and after reset until the first result arrives, out_vld is low and out_re, out_im, out_row and out_col are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input point valid |
| in_row | input | N_LOG | Row frequency index p |
| in_col | input | N_LOG | Column frequency index q |
| fx_re | input | IN_W | x-gradient spectrum, real part |
| fx_im | input | IN_W | x-gradient spectrum, imaginary part |
| fy_re | input | IN_W | y-gradient spectrum, real part |
| fy_im | input | IN_W | y-gradient spectrum, imaginary part |
| out_vld | output | 1 | Output coefficient valid |
| out_row | output | N_LOG | Row index of the output point |
| out_col | output | N_LOG | Column index of the output point |
| out_re | output | OUT_W | Output coefficient, real part |
| out_im | output | OUT_W | Output coefficient, imaginary part |

## Verification
Input clamping and output clamping can both act on the same point. The bench sends full-scale positive words on both streams at point (1,1). There the 18-bit reduction clamps each word, and the sum of the two weighted products then overflows the 16-bit range. The expected value, computed in the bench, is the clamped maximum. The bench sends this point back to back with a DC point and a half-way rounding point, so the next output shows that neither clamp leaks into the following sample.

// File: rtl/sf_pkg.sv
package sf_pkg;

  // signed spatial frequency of a grid index
  function automatic int sgn_freq(input int idx, input int n_log);
    if (idx < (1 << (n_log - 1))) return idx;
    return idx - (1 << n_log);
  endfunction

  // imaginary weight entry: s(a) * 2^frac / (s(a)^2 + s(b)^2), rounded away from zero
  function automatic int wt_im(input int a, input int b, input int n_log, input int frac);
    int sa;
    int sb;
    int den;
    int num;
    sa  = sgn_freq(a, n_log);
    sb  = sgn_freq(b, n_log);
    den = sa * sa + sb * sb;
    if (den == 0) return 0;
    num = sa * (1 << frac);
    if (num >= 0) return (num + den / 2) / den;
    return -((-num + den / 2) / den);
  endfunction

endpackage

// File: rtl/sf_rst_sync.sv
module sf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/sf_rndsat.sv
module sf_rndsat #(
  parameter int IN_W  = 24,
  parameter int SH    = 6,
  parameter int OUT_W = 18
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  localparam int T_W = IN_W + 1;
  localparam int R_W = T_W - SH;
  localparam logic signed [T_W-1:0] HALF = T_W'(1) << (SH - 1);
  localparam logic signed [R_W-1:0] HI   = R_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [R_W-1:0] LO   = -HI - R_W'(1);

  logic signed [T_W-1:0] t;
  logic signed [R_W-1:0] r;

  always_comb begin
    t = T_W'(x) + HALF;
    r = t[T_W-1:SH];
    if (r > HI)      y = HI[OUT_W-1:0];
    else if (r < LO) y = LO[OUT_W-1:0];
    else             y = r[OUT_W-1:0];
  end
endmodule

// File: rtl/sf_weight_rom.sv
module sf_weight_rom #(
  parameter int N_LOG  = 3,
  parameter int W_W    = 16,
  parameter int W_FRAC = 14
) (
  input  logic [N_LOG-1:0]      row,
  input  logic [N_LOG-1:0]      col,
  output logic signed [W_W-1:0] wx_re,
  output logic signed [W_W-1:0] wx_im,
  output logic signed [W_W-1:0] wy_re,
  output logic signed [W_W-1:0] wy_im
);
  localparam int NPTS = 1 << (2 * N_LOG);
  localparam int NSIDE = 1 << N_LOG;

  // one table; real plane is zero for every entry
  logic signed [W_W-1:0] tbl_re [NPTS];
  logic signed [W_W-1:0] tbl_im [NPTS];

  for (genvar g = 0; g < NPTS; g++) begin : g_tbl
    assign tbl_re[g] = '0;
    assign tbl_im[g] = W_W'(sf_pkg::wt_im(g / NSIDE, g % NSIDE, N_LOG, W_FRAC));
  end

  // y path reads the transpose: indices swapped
  assign wx_re = tbl_re[{row, col}];
  assign wx_im = tbl_im[{row, col}];
  assign wy_re = tbl_re[{col, row}];
  assign wy_im = tbl_im[{col, row}];
endmodule

// File: rtl/sf_cmul.sv
module sf_cmul #(
  parameter int A_W = 18,
  parameter int B_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [A_W-1:0]    a_re,
  input  logic signed [A_W-1:0]    a_im,
  input  logic signed [B_W-1:0]    b_re,
  input  logic signed [B_W-1:0]    b_im,
  output logic                     out_vld,
  output logic signed [A_W+B_W:0]  p_re,
  output logic signed [A_W+B_W:0]  p_im
);
  localparam int M_W = A_W + B_W;
  localparam int P_W = M_W + 1;

  logic                  v1, v2, v3;
  logic signed [A_W-1:0] a_re_q, a_im_q;
  logic signed [B_W-1:0] b_re_q, b_im_q;
  logic signed [M_W-1:0] rr_q, ii_q, ri_q, ir_q;
  logic signed [M_W-1:0] rr_n, ii_n, ri_n, ir_n;
  logic signed [P_W-1:0] re_q, im_q, re_n, im_n;

  always_comb begin
    rr_n = a_re_q * b_re_q;
    ii_n = a_im_q * b_im_q;
    ri_n = a_re_q * b_im_q;
    ir_n = a_im_q * b_re_q;
    re_n = P_W'(rr_q) - P_W'(ii_q);
    im_n = P_W'(ri_q) + P_W'(ir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_vld <= 1'b0;
      a_re_q <= '0; a_im_q <= '0; b_re_q <= '0; b_im_q <= '0;
      rr_q <= '0; ii_q <= '0; ri_q <= '0; ir_q <= '0;
      re_q <= '0; im_q <= '0; p_re <= '0; p_im <= '0;
    end else begin
      v1 <= in_vld;
      v2 <= v1;
      v3 <= v2;
      out_vld <= v3;
      if (in_vld) begin
        a_re_q <= a_re; a_im_q <= a_im; b_re_q <= b_re; b_im_q <= b_im;
      end
      if (v1) begin
        rr_q <= rr_n; ii_q <= ii_n; ri_q <= ri_n; ir_q <= ir_n;
      end
      if (v2) begin
        re_q <= re_n; im_q <= im_n;
      end
      if (v3) begin
        p_re <= re_q; p_im <= im_q;
      end
    end
  end
endmodule

// File: rtl/sf_slope_filter.sv
module sf_slope_filter #(
  parameter int N_LOG  = 3,
  parameter int IN_W   = 24,
  parameter int MUL_W  = 18,
  parameter int W_W    = 16,
  parameter int W_FRAC = 14,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [N_LOG-1:0]        in_row,
  input  logic [N_LOG-1:0]        in_col,
  input  logic signed [IN_W-1:0]  fx_re,
  input  logic signed [IN_W-1:0]  fx_im,
  input  logic signed [IN_W-1:0]  fy_re,
  input  logic signed [IN_W-1:0]  fy_im,
  output logic                    out_vld,
  output logic [N_LOG-1:0]        out_row,
  output logic [N_LOG-1:0]        out_col,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  localparam int IN_SH  = IN_W - MUL_W;
  localparam int P_W    = MUL_W + W_W + 1;
  localparam int S_W    = P_W + 1;
  localparam int OUT_SH = W_FRAC + MUL_W - OUT_W;
  localparam int LAT    = 7;
  localparam int TAG_W  = 2 * N_LOG;
  localparam int N_LANE = 4;

  logic rst_s_n;

  sf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  // ---- stage A: input rounding and weight lookup ----
  logic signed [IN_W-1:0]  lane_in  [N_LANE];
  logic signed [MUL_W-1:0] lane_rnd [N_LANE];
  logic signed [MUL_W-1:0] lane_q   [N_LANE];
  logic signed [W_W-1:0]   wx_re, wx_im, wy_re, wy_im;
  logic signed [W_W-1:0]   wx_re_q, wx_im_q, wy_re_q, wy_im_q;
  logic                    vld_a;

  assign lane_in[0] = fx_re;
  assign lane_in[1] = fx_im;
  assign lane_in[2] = fy_re;
  assign lane_in[3] = fy_im;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    sf_rndsat #(.IN_W(IN_W), .SH(IN_SH), .OUT_W(MUL_W)) u_rin (
      .x(lane_in[l]), .y(lane_rnd[l])
    );
  end

  sf_weight_rom #(.N_LOG(N_LOG), .W_W(W_W), .W_FRAC(W_FRAC)) u_rom (
    .row(in_row), .col(in_col),
    .wx_re(wx_re), .wx_im(wx_im), .wy_re(wy_re), .wy_im(wy_im)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_a <= 1'b0;
      for (int l = 0; l < N_LANE; l++) lane_q[l] <= '0;
      wx_re_q <= '0; wx_im_q <= '0; wy_re_q <= '0; wy_im_q <= '0;
    end else begin
      vld_a <= in_vld;
      if (in_vld) begin
        for (int l = 0; l < N_LANE; l++) lane_q[l] <= lane_rnd[l];
        wx_re_q <= wx_re; wx_im_q <= wx_im; wy_re_q <= wy_re; wy_im_q <= wy_im;
      end
    end
  end

  // ---- complex weighting, both gradients in lockstep ----
  logic                  vx, vy;
  logic signed [P_W-1:0] px_re, px_im, py_re, py_im;

  sf_cmul #(.A_W(MUL_W), .B_W(W_W)) u_mx (
    .clk(clk), .rst_n(rst_s_n), .in_vld(vld_a),
    .a_re(lane_q[0]), .a_im(lane_q[1]), .b_re(wx_re_q), .b_im(wx_im_q),
    .out_vld(vx), .p_re(px_re), .p_im(px_im)
  );

  sf_cmul #(.A_W(MUL_W), .B_W(W_W)) u_my (
    .clk(clk), .rst_n(rst_s_n), .in_vld(vld_a),
    .a_re(lane_q[2]), .a_im(lane_q[3]), .b_re(wy_re_q), .b_im(wy_im_q),
    .out_vld(vy), .p_re(py_re), .p_im(py_im)
  );

  // ---- sum and output rounding ----
  logic                    vld_m, vld_s;
  logic signed [S_W-1:0]   sum_re_n, sum_im_n, sum_re_q, sum_im_q;
  logic signed [OUT_W-1:0] o_re_n, o_im_n;

  assign vld_m = vx & vy;

  always_comb begin
    sum_re_n = S_W'(px_re) + S_W'(py_re);
    sum_im_n = S_W'(px_im) + S_W'(py_im);
  end

  sf_rndsat #(.IN_W(S_W), .SH(OUT_SH), .OUT_W(OUT_W)) u_ro_re (.x(sum_re_q), .y(o_re_n));
  sf_rndsat #(.IN_W(S_W), .SH(OUT_SH), .OUT_W(OUT_W)) u_ro_im (.x(sum_im_q), .y(o_im_n));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_s <= 1'b0; out_vld <= 1'b0;
      sum_re_q <= '0; sum_im_q <= '0;
      out_re <= '0; out_im <= '0;
    end else begin
      vld_s   <= vld_m;
      out_vld <= vld_s;
      if (vld_m) begin
        sum_re_q <= sum_re_n; sum_im_q <= sum_im_n;
      end
      if (vld_s) begin
        out_re <= o_re_n; out_im <= o_im_n;
      end
    end
  end

  // ---- index tags travel with the data ----
  logic [TAG_W-1:0] tag_q [LAT];
  logic [LAT-2:0]   tvld_q;
  logic [LAT-1:0]   tag_en;

  always_comb begin
    tag_en[0] = in_vld;
    for (int i = 1; i < LAT; i++) tag_en[i] = tvld_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tvld_q <= '0;
      for (int i = 0; i < LAT; i++) tag_q[i] <= '0;
    end else begin
      tvld_q <= tag_en[LAT-2:0];
      if (tag_en[0]) tag_q[0] <= {in_row, in_col};
      for (int i = 1; i < LAT; i++) begin
        if (tag_en[i]) tag_q[i] <= tag_q[i-1];
      end
    end
  end

  assign out_row = tag_q[LAT-1][TAG_W-1:N_LOG];
  assign out_col = tag_q[LAT-1][N_LOG-1:0];
endmodule

// File: rtl/sf_slope_filter_chk.sv
module sf_slope_filter_chk #(
  parameter int N_LOG = 3,
  parameter int IN_W  = 24,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [N_LOG-1:0] in_row,
  input logic [N_LOG-1:0] in_col,
  input logic [IN_W-1:0]  fx_re,
  input logic [IN_W-1:0]  fx_im,
  input logic [IN_W-1:0]  fy_re,
  input logic [IN_W-1:0]  fy_im,
  input logic             out_vld,
  input logic [N_LOG-1:0] out_row,
  input logic [N_LOG-1:0] out_col,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im
);
  logic [3:0] up_cnt;
  logic       in_zero;

  assign in_zero = (fx_re == '0) && (fx_im == '0) && (fy_re == '0) && (fy_im == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 4'hF) up_cnt <= up_cnt + 4'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 4'd8) |-> (out_vld == $past(in_vld, 7))); // R7

  AST_TAG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 4'd8 && out_vld) |-> (out_row == $past(in_row, 7) && out_col == $past(in_col, 7))); // R8

  AST_DC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_row == '0 && out_col == '0) |-> (out_re == '0 && out_im == '0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 4'd1 && !out_vld) |-> ($stable(out_re) && $stable(out_im))); // R9

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 4'd8 && out_vld && $past(in_zero, 7)) |-> (out_re == '0 && out_im == '0)); // R1
endmodule

bind sf_slope_filter sf_slope_filter_chk #(.N_LOG(N_LOG), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .in_vld(in_vld), .in_row(in_row), .in_col(in_col),
  .fx_re(fx_re), .fx_im(fx_im), .fy_re(fy_re), .fy_im(fy_im),
  .out_vld(out_vld), .out_row(out_row), .out_col(out_col),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/sim_sf_slope_filter.sv
module sim_sf_slope_filter;
  localparam int CLK_P   = 10;
  localparam int LAT_EXP = 7;
  localparam int QD      = 512;

  logic clk, rst_n, in_vld, out_vld;
  logic [2:0] in_row, in_col, out_row, out_col;
  logic signed [23:0] fx_re, fx_im, fy_re, fy_im;
  logic signed [15:0] out_re, out_im;

  sf_slope_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_row(in_row), .in_col(in_col),
    .fx_re(fx_re), .fx_im(fx_im), .fy_re(fy_re), .fy_im(fy_im),
    .out_vld(out_vld), .out_row(out_row), .out_col(out_col),
    .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit seen = 0;
  logic signed [15:0] last_re, last_im;
  int unsigned seed = 32'h1234_5678;

  longint exp_re [QD];
  longint exp_im [QD];
  int     exp_row [QD];
  int     exp_col [QD];
  int     exp_cyc [QD];
  string  exp_req [QD];
  int wr = 0;
  int rd = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference arithmetic from the requirements
  function automatic longint rin(input longint x);    // R5
    longint t;
    t = (x + 32) >>> 6;
    if (t > 131071) t = 131071;
    if (t < -131072) t = -131072;
    return t;
  endfunction

  function automatic longint sfreq(input int i);      // R3
    return (i < 4) ? longint'(i) : longint'(i - 8);
  endfunction

  function automatic longint tw(input int a, input int b); // R1
    longint sa, sb, d, n;
    sa = sfreq(a); sb = sfreq(b);
    d = sa * sa + sb * sb;
    if (d == 0) return 0;
    n = sa * 16384;
    if (n >= 0) return (n + d / 2) / d;
    return -((-n + d / 2) / d);
  endfunction

  function automatic longint rout(input longint s);   // R6
    longint t;
    t = (s + 32768) >>> 16;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic longint rnd24(input bit full);
    seed = seed * 32'd1103515245 + 32'd12345;
    if (full) return longint'($signed(seed[31:8]));
    return longint'($signed(seed[28:16]));
  endfunction

  task automatic send(input int r, input int c, input longint xr, input longint xi,
                      input longint yr, input longint yi, input string req);
    longint wxv, wyv;
    @(negedge clk);
    in_vld = 1'b1;
    in_row = 3'(r); in_col = 3'(c);
    fx_re = 24'(xr); fx_im = 24'(xi); fy_re = 24'(yr); fy_im = 24'(yi);
    wxv = tw(r, c);
    wyv = tw(c, r);                                     // R2: swapped indices
    exp_re[wr % QD]  = rout(-(rin(xi) * wxv + rin(yi) * wyv));
    exp_im[wr % QD]  = rout(rin(xr) * wxv + rin(yr) * wyv);
    exp_row[wr % QD] = r;
    exp_col[wr % QD] = c;
    exp_cyc[wr % QD] = cyc;
    exp_req[wr % QD] = req;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0;
      fx_re = 24'(rnd24(1'b1)); fy_im = 24'(rnd24(1'b1));
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (rd == wr) begin
          check(1'b0, "R7", "unexpected out_vld", 1, 0);
        end else begin
          check(longint'(out_re) == exp_re[rd % QD], exp_req[rd % QD], "out_re",
                longint'(out_re), exp_re[rd % QD]);
          check(longint'(out_im) == exp_im[rd % QD], exp_req[rd % QD], "out_im",
                longint'(out_im), exp_im[rd % QD]);
          check(int'(out_row) == exp_row[rd % QD] && int'(out_col) == exp_col[rd % QD],
                "R8", "out_row*8+out_col", longint'(out_row) * 8 + longint'(out_col),
                longint'(exp_row[rd % QD] * 8 + exp_col[rd % QD]));
          check(cyc - exp_cyc[rd % QD] == LAT_EXP, "R7", "latency",
                longint'(cyc - exp_cyc[rd % QD]), LAT_EXP);
          rd++;
        end
        last_re = out_re; last_im = out_im; seen = 1'b1;
      end else if (seen) begin
        check(out_re == last_re && out_im == last_im, "R9", "held out_re",
              longint'(out_re), longint'(last_re));
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_row = '0; in_col = '0;
    fx_re = '0; fx_im = '0; fy_re = '0; fy_im = '0;
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0 && out_re == '0 && out_im == '0 && out_row == '0, "R10",
          "outputs in reset", longint'(out_re), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0 && out_re == '0 && out_im == '0 && out_col == '0, "R10",
          "outputs after reset", longint'(out_vld), 0);
    mon_on = 1'b1;

    // sweep 1: all points, small values, back to back (R1 R2 R3 R4)
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        send(r, c, rnd24(1'b0), rnd24(1'b0), rnd24(1'b0), rnd24(1'b0),
             (r == 0 && c == 0) ? "R4" : "R1 R2 R3");
    idle(3);

    // sweep 2: all points, full-range values, back to back (R5 R6)
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        send(r, c, rnd24(1'b1), rnd24(1'b1), rnd24(1'b1), rnd24(1'b1),
             (r == 0 && c == 0) ? "R4" : "R1 R5 R6");
    idle(2);

    // sweep 3: reverse order with a bubble after each point (R9)
    for (int g = 63; g >= 0; g--) begin
      send(g / 8, g % 8, rnd24(1'b0), rnd24(1'b1), rnd24(1'b1), rnd24(1'b0),
           (g == 0) ? "R4" : "R1 R9");
      idle(1 + g % 3);
    end

    // directed: both clamps on one point, then DC, then half-way rounding
    send(1, 1, 64'sd8388607, 0, 64'sd8388607, 0, "R5 R6 saturate");
    send(0, 0, 64'sd8388607, -64'sd8388608, 64'sd8388607, 64'sd8388607, "R4");
    send(1, 0, 96, 0, 0, 0, "R5 R6 half-up");
    send(1, 1, -64'sd8388608, 0, -64'sd8388608, 0, "R5 R6 negative full scale");
    send(4, 0, 0, 64'sd4000000, 0, 64'sd4000000, "R3 negative frequency");
    send(2, 5, 64'sd1000000, 64'sd2000000, -64'sd3000000, 64'sd500000, "R2 transpose");
    idle(LAT_EXP + 5);

    check(rd == wr, "R7", "all results delivered", rd, wr);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", rd, wr);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule